// File: doc/BRIEF.md
# Request/Acknowledge Passive Receiver

This block takes single data words from an outside sender whose clock has no relation to the local clock. The two sides coordinate over a four-phase request/acknowledge exchange, and the receiver only ever answers. It waits for the sender's request and captures the data bus into a holding register. It then raises acknowledge and keeps it high until the request is withdrawn. After that it drops acknowledge, which completes the transfer and frees the sender to start the next one.

The request line is brought into the local clock domain through a chain of flip-flops before the control logic reads it. The data bus is not synchronised. It is sampled only once the synchronised request is high, and it relies on the sender holding the bus steady from before it raises the request until it sees acknowledge. Local logic gets the captured word on a steady output and a one-cycle strobe that marks each new word.

Top module: `hs_passive_rx`

## Requirements
- R1: In the cycle after a synchronous reset `rst` is sampled high, `ack_o` and `valid_o` are low and `data_o` is all zeros; the receiver then waits for a request.
- R2: While `req_i` stays low, `ack_o` and `valid_o` stay low and `data_o` keeps its value, whatever `data_i` does.
- R3: The word on `data_i` while the request is high is captured and shown on `data_o` by the time acknowledge rises.
- R4: `ack_o` rises at the fourth rising clock edge after `req_i` rises: two synchroniser stages, one capture cycle and one acknowledge cycle. It is still low after the third edge.
- R5: `valid_o` is high for exactly one cycle per transfer, and that cycle is the first cycle in which `ack_o` is high.
- R6: `ack_o` stays high for as long as `req_i` stays high, and `data_o` does not follow changes on `data_i` while acknowledge is high.
- R7: `ack_o` falls at the third rising edge after `req_i` falls, and is still high after the second.
- R8: Once acknowledge has dropped, a new request starts a new transfer with the same timing, so transfers can follow one another back to back.
- R9: A reset in the middle of a transfer, with acknowledge high, returns the receiver to waiting with `ack_o` and `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request from the outside sender, asynchronous to `clk` |
| data_i | input | DATA_W | Data bus from the sender, held steady while the request is high |
| ack_o | output | 1 | Acknowledge back to the sender |
| data_o | output | DATA_W | Most recently captured word |
| valid_o | output | 1 | One-cycle strobe when a new word is shown on `data_o` |

## Verification
The bench drives `req_i` on falling edges and counts rising edges from there. Acknowledge is due after the fourth edge following a rising request, and after the third edge following a falling one. The captured word and the valid strobe appear together with the rising acknowledge, and the strobe is gone one edge later. Each task samples on the falling edge after the exact edge count, and it also checks that the output has not moved one edge earlier. This catches a stage added to or removed from the path.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_REQ  = 2'd0,
        ST_CAPTURED  = 2'd1,
        ST_WAIT_DROP = 2'd2
    } hs_state_e;

    typedef struct packed {
        hs_state_e state;
        logic      ack;
        logic      valid;
    } hs_ctrl_t;

    localparam hs_ctrl_t HS_CTRL_RESET = '{state: ST_WAIT_REQ, ack: 1'b0, valid: 1'b0};

endpackage

// File: rtl/hs_req_sync.sv
module hs_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[N-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[N-1];
endmodule

// File: rtl/hs_hold_reg.sv
module hs_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) word_d = d_i;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign q_o = word_q;
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_s_i,
    output logic      load_o,
    output logic      ack_o,
    output logic      valid_o,
    output hs_state_e state_o
);
    hs_ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        load_o      = 1'b0;
        unique case (cur_q.state)
            ST_WAIT_REQ: begin
                nxt_d.ack = 1'b0;
                if (req_s_i) begin
                    load_o      = 1'b1;
                    nxt_d.state = ST_CAPTURED;
                end
            end
            ST_CAPTURED: begin
                nxt_d.ack   = 1'b1;
                nxt_d.valid = 1'b1;
                nxt_d.state = ST_WAIT_DROP;
            end
            ST_WAIT_DROP: begin
                if (!req_s_i) begin
                    nxt_d.ack   = 1'b0;
                    nxt_d.state = ST_WAIT_REQ;
                end
            end
            default: nxt_d = HS_CTRL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= HS_CTRL_RESET;
        else     cur_q <= nxt_d;
    end

    assign ack_o   = cur_q.ack;
    assign valid_o = cur_q.valid;
    assign state_o = cur_q.state;
endmodule

// File: rtl/hs_passive_rx.sv
module hs_passive_rx
    import hs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    logic      req_sync;
    logic      cap_load;
    hs_state_e ctrl_state;

    hs_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (req_i),
        .sync_o  (req_sync)
    );

    hs_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req_s_i (req_sync),
        .load_o  (cap_load),
        .ack_o   (ack_o),
        .valid_o (valid_o),
        .state_o (ctrl_state)
    );

    hs_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (cap_load),
        .d_i    (data_i),
        .q_o    (data_o)
    );
endmodule

// File: rtl/hs_passive_rx_chk.sv
module hs_passive_rx_chk
    import hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_s,
    input hs_state_e         state_q,
    input logic              ack_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] data_o
);
    // R1: reset clears the handshake outputs
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ack_o && !valid_o));

    // R2: waiting with no request gives no response
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_REQ && !req_s) |=> (!ack_o && !valid_o));

    // R5: strobe lasts one cycle
    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R5: strobe marks the first acknowledge cycle
    p_valid_on_ack_rise_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (ack_o && !$past(ack_o)));

    // R6: acknowledge holds while the request is seen
    p_ack_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_o && req_s) |=> ack_o);

    // R6: captured word is frozen during acknowledge
    p_data_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !valid_o) |-> $stable(data_o));
endmodule

bind hs_passive_rx hs_passive_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_s   (req_sync),
    .state_q (ctrl_state),
    .ack_o   (ack_o),
    .valid_o (valid_o),
    .data_o  (data_o)
);

// File: tb/hs_passive_rx_test.sv
module hs_passive_rx_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [DW-1:0] din = '0;
    logic          ack;
    logic [DW-1:0] dout;
    logic          valid;

    int n_run  = 0;
    int n_fail = 0;
    int n_valid = 0;
    int cycles = 0;

    hs_passive_rx #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .req_i(req), .data_i(din),
        .ack_o(ack), .data_o(dout), .valid_o(valid)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (valid) n_valid++;
        cycles++;
    end

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        step(3);
        chk("R1 ack", ack, 0);
        chk("R1 valid", valid, 0);
        chk("R1 data", dout, 0);
        rst = 1'b0;
        step(1);
    endtask

    task automatic test_idle();
        int v0;
        v0 = n_valid;
        for (int i = 0; i < 10; i++) begin
            din = DW'(8'h30 + i);
            step(1);
            chk("R2 ack", ack, 0);
        end
        chk("R2 data", dout, 0);
        chk("R2 valid", n_valid - v0, 0);
    endtask

    task automatic transfer(input logic [DW-1:0] w, input int hold, input string tag);
        int v0;
        v0 = n_valid;
        din = w;
        req = 1'b1;
        step(3);
        chk({tag, " R4 early"}, ack, 0);
        step(1);
        chk({tag, " R4 ack"}, ack, 1);
        chk({tag, " R5 valid"}, valid, 1);
        chk({tag, " R3 data"}, dout, w);
        step(1);
        chk({tag, " R5 pulse"}, valid, 0);
        for (int i = 0; i < hold; i++) begin
            din = ~w ^ DW'(i);
            step(1);
            chk({tag, " R6 ack"}, ack, 1);
            chk({tag, " R6 data"}, dout, w);
        end
        req = 1'b0;
        step(2);
        chk({tag, " R7 early"}, ack, 1);
        step(1);
        chk({tag, " R7 ack"}, ack, 0);
        chk({tag, " R5 count"}, n_valid - v0, 1);
    endtask

    task automatic test_back_to_back();
        transfer(8'hA5, 2, "R8 a");
        transfer(8'h5A, 0, "R8 b");
        transfer(8'hFF, 1, "R8 c");
        chk("R8 final data", dout, 8'hFF);
    endtask

    task automatic test_mid_reset();
        din = 8'h77;
        req = 1'b1;
        step(4);
        chk("R9 pre ack", ack, 1);
        rst = 1'b1;
        req = 1'b0;
        step(1);
        chk("R9 ack", ack, 0);
        chk("R9 valid", valid, 0);
        rst = 1'b0;
        step(6);
        chk("R9 stays idle", ack, 0);
    endtask

    initial begin
        test_reset();
        test_idle();
        transfer(8'h3C, 0, "basic");
        transfer(8'hC3, 12, "long");
        test_back_to_back();
        test_mid_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule